// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block keeps the pending-event flags of a 16-bit timer that has eight capture/compare channels. It holds the free-running counter, one flag per channel and an overflow flag. It raises one interrupt request from those flags and their enable masks. Hardware strobes set the flags. Software clears them over a small register bus, either by writing ones to the flag registers or, when the fast-clear mode input is high, as a side effect of touching the counter or a channel's data register.

A channel's data register is treated as a capture register or a compare register according to its bit of `chan_mode`. That choice decides which access clears the channel's flag in fast-clear mode. Capture latching, compare matching and prescaling live elsewhere. Reads of the channel data registers return zero here.

The bus is a single-cycle interface. A request qualified by `bus_req` takes effect at the next rising clock edge. Read data is combinational from the current state.

Top module: `tfc_top`

## Requirements
- R1: After reset the channel flags, the overflow flag, the counter and both interrupt-enable registers read zero, and `irq` is low.
- R2: A high `ch_evt[i]` at a clock edge sets bit i of the channel flag register (address 0x0C) at that edge.
- R3: The counter advances by one on each edge while `tmr_en` or `pacc_en` is high and holds while both are low. Its upper byte reads at address 0x04 and its lower byte at 0x05.
- R4: When the counter advances from 0xFFFF to 0x0000, bit 7 of the overflow flag register (address 0x0D) is set. Bits 6..0 of that register always read zero.
- R5: A bus write to 0x0C clears every channel flag whose data bit is 1. A write to 0x0D with bit 7 set clears the overflow flag. Zero bits leave flags unchanged. This applies only while `tmr_en` or `pacc_en` is high.
- R6: While `tmr_en` and `pacc_en` are both low, writes to 0x0C and 0x0D change no flag.
- R7: With `fast_clr` high, any read or write of address 0x04 or 0x05 clears the overflow flag.
- R8: With `fast_clr` high, an access to address 0x10+2i or 0x11+2i clears channel flag i. The access must be a read when `chan_mode[i]`=0 (capture) or a write when `chan_mode[i]`=1 (compare). The other access kind, or any access with `fast_clr` low, leaves the flag unchanged.
- R9: When a set event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R10: Address 0x0A holds the channel interrupt enables (bit i for channel i). Bit 7 of 0x0B holds the overflow enable, and its other bits read zero. `irq` is high exactly when some flag and its enable are both 1.
- R11: Both flag registers read back their current value at any time, whatever the enables and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_en | input | 1 | Timer enable |
| pacc_en | input | 1 | Pulse-accumulator enable |
| fast_clr | input | 1 | Fast-clear mode |
| chan_mode | input | 8 | Per-channel role, 1 = compare, 0 = capture |
| ch_evt | input | 8 | Per-channel capture/compare event strobes |
| bus_req | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| ch_flags | output | 8 | Channel flag register |
| ovf_flags | output | 8 | Overflow flag register (bit 7 only) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is the counter wrap landing in the same cycle as a clear of the overflow flag, because the wrap comes only once per 65536 enabled cycles. The stimulus runs the counter up to 0xFFFF twice. The first time it issues a write-one clear of the overflow flag in the exact wrap cycle. The second time it issues a fast-clear counter read in the wrap cycle, and then it confirms that a later access does clear the flag. Channel set/clear collisions and the capture-versus-compare choice are covered by a seeded random phase that mixes event strobes, enable and mode changes with accesses across the whole address space.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;
    localparam int NCH    = 8;
    localparam int CNT_W  = 16;
    localparam int IDX_W  = $clog2(NCH);

    localparam logic [ADDR_W-1:0] A_CNT_HI = 6'h04;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 6'h05;
    localparam logic [ADDR_W-1:0] A_CH_IE  = 6'h0A;
    localparam logic [ADDR_W-1:0] A_OV_IE  = 6'h0B;
    localparam logic [ADDR_W-1:0] A_CH_FLG = 6'h0C;
    localparam logic [ADDR_W-1:0] A_OV_FLG = 6'h0D;
    // channel data registers occupy 0x10..0x1F, two bytes per channel
    localparam logic [1:0]        CHAN_PAGE = 2'b01;
    localparam int                OV_BIT    = 7;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_COUNTER,
        ACC_CHAN,
        ACC_CH_FLAG,
        ACC_OV_FLAG,
        ACC_CH_IE,
        ACC_OV_IE,
        ACC_OTHER
    } acc_e;
endpackage

// File: rtl/tfc_counter.sv
module tfc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

    // advancing from all ones rolls over to zero
    assign wrap = run & (&cnt);
endmodule

// File: rtl/tfc_flag_bank.sv
module tfc_flag_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    // set is applied after clear, so a coincident event survives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr) | set;
        end
    end
endmodule

// File: rtl/tfc_decode.sv
module tfc_decode
    import tfc_pkg::*;
(
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              fast_clr,
    input  logic              clr_ok,
    input  logic [NCH-1:0]    chan_mode,
    output acc_e              kind,
    output logic [NCH-1:0]    ch_clr,
    output logic              ov_clr,
    output logic              ch_ie_we,
    output logic              ov_ie_we
);
    logic [IDX_W-1:0] idx;
    assign idx = bus_addr[IDX_W:1];

    always_comb begin
        if (!bus_req) begin
            kind = ACC_IDLE;
        end else if (bus_addr[5:4] == CHAN_PAGE) begin
            kind = ACC_CHAN;
        end else begin
            unique case (bus_addr)
                A_CNT_HI, A_CNT_LO: kind = ACC_COUNTER;
                A_CH_FLG:           kind = ACC_CH_FLAG;
                A_OV_FLG:           kind = ACC_OV_FLAG;
                A_CH_IE:            kind = ACC_CH_IE;
                A_OV_IE:            kind = ACC_OV_IE;
                default:            kind = ACC_OTHER;
            endcase
        end
    end

    always_comb begin
        ch_clr   = '0;
        ov_clr   = 1'b0;
        ch_ie_we = 1'b0;
        ov_ie_we = 1'b0;
        unique case (kind)
            ACC_COUNTER: ov_clr = fast_clr;
            ACC_CHAN: begin
                // compare role clears on write, capture role on read
                if (fast_clr && (chan_mode[idx] == bus_wr)) begin
                    ch_clr[idx] = 1'b1;
                end
            end
            ACC_CH_FLAG: begin
                if (bus_wr && clr_ok) ch_clr = bus_wdata[NCH-1:0];
            end
            ACC_OV_FLAG: begin
                if (bus_wr && clr_ok) ov_clr = bus_wdata[OV_BIT];
            end
            ACC_CH_IE: ch_ie_we = bus_wr;
            ACC_OV_IE: ov_ie_we = bus_wr;
            default: ;
        endcase
    end
endmodule

// File: rtl/tfc_top.sv
module tfc_top
    import tfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_en,
    input  logic              pacc_en,
    input  logic              fast_clr,
    input  logic [NCH-1:0]    chan_mode,
    input  logic [NCH-1:0]    ch_evt,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] ch_flags,
    output logic [DATA_W-1:0] ovf_flags,
    output logic              irq
);
    logic             run;
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;
    acc_e             kind;
    logic [NCH-1:0]   ch_clr;
    logic             ov_clr;
    logic             ch_ie_we;
    logic             ov_ie_we;
    logic [NCH-1:0]   ch_q;
    logic [0:0]       ov_q;
    logic [NCH-1:0]   ch_ie_q;
    logic             ov_ie_q;

    assign run = tmr_en | pacc_en;

    tfc_counter #(.W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .cnt  (cnt_q),
        .wrap (wrap)
    );

    tfc_decode u_dec (
        .bus_req  (bus_req),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .fast_clr (fast_clr),
        .clr_ok   (run),
        .chan_mode(chan_mode),
        .kind     (kind),
        .ch_clr   (ch_clr),
        .ov_clr   (ov_clr),
        .ch_ie_we (ch_ie_we),
        .ov_ie_we (ov_ie_we)
    );

    tfc_flag_bank #(.N(NCH)) u_chf (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (ch_evt),
        .clr  (ch_clr),
        .flags(ch_q)
    );

    tfc_flag_bank #(.N(1)) u_ovf (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (wrap),
        .clr  (ov_clr),
        .flags(ov_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_ie_q <= '0;
            ov_ie_q <= 1'b0;
        end else begin
            if (ch_ie_we) ch_ie_q <= bus_wdata[NCH-1:0];
            if (ov_ie_we) ov_ie_q <= bus_wdata[OV_BIT];
        end
    end

    assign ch_flags  = ch_q;
    assign ovf_flags = {ov_q[0], {(DATA_W-1){1'b0}}};
    assign irq       = (|(ch_q & ch_ie_q)) | (ov_q[0] & ov_ie_q);

    always_comb begin
        unique case (kind)
            ACC_COUNTER: bus_rdata = bus_addr[0] ? cnt_q[7:0] : cnt_q[15:8];
            ACC_CH_FLAG: bus_rdata = ch_q;
            ACC_OV_FLAG: bus_rdata = ovf_flags;
            ACC_CH_IE:   bus_rdata = ch_ie_q;
            ACC_OV_IE:   bus_rdata = {ov_ie_q, {(DATA_W-1){1'b0}}};
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tfc_checker.sv
module tfc_checker
    import tfc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tmr_en,
    input logic              pacc_en,
    input logic              fast_clr,
    input logic [NCH-1:0]    ch_evt,
    input logic              bus_req,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] ch_flags,
    input logic [DATA_W-1:0] ovf_flags,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt
);
    logic en;
    assign en = tmr_en | pacc_en;

    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ch_evt != '0 |=> (ch_flags & $past(ch_evt)) == $past(ch_evt));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> cnt == $past(cnt));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en && !(&cnt) |=> cnt == $past(cnt) + 16'd1);

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en && (&cnt) |=> ovf_flags[OV_BIT] && cnt == '0);

    p_rsvd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flags[OV_BIT-1:0] == '0);

    p_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_wr && bus_addr == A_CH_FLG && !en
        |=> ch_flags == ($past(ch_flags) | $past(ch_evt)));

    p_fc_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && fast_clr && (bus_addr == A_CNT_HI || bus_addr == A_CNT_LO)
        && !(en && (&cnt)) |=> !ovf_flags[OV_BIT]);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_wr && bus_addr == A_OV_FLG && en && (&cnt)
        |=> ovf_flags[OV_BIT]);

    p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ch_flags != '0 || ovf_flags[OV_BIT]));
endmodule

bind tfc_top tfc_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tmr_en   (tmr_en),
    .pacc_en  (pacc_en),
    .fast_clr (fast_clr),
    .ch_evt   (ch_evt),
    .bus_req  (bus_req),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .ch_flags (ch_flags),
    .ovf_flags(ovf_flags),
    .irq      (irq),
    .cnt      (cnt_q)
);

// File: tb/sim_tfc_top.sv
module sim_tfc_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tmr_en = 1'b0, pacc_en = 1'b0, fast_clr = 1'b0;
    logic [7:0] chan_mode = '0, ch_evt = '0;
    logic       bus_req = 1'b0, bus_wr = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, ch_flags, ovf_flags;
    logic       irq;

    int total = 0;
    int fails = 0;

    // reference model state
    logic [7:0]  m_ch = '0, m_cie = '0;
    logic        m_ov = 1'b0, m_oie = 1'b0;
    logic [15:0] m_cnt = '0;

    always #10 clk = ~clk;

    tfc_top u0 (
        .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .pacc_en(pacc_en),
        .fast_clr(fast_clr), .chan_mode(chan_mode), .ch_evt(ch_evt),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_flags(ch_flags),
        .ovf_flags(ovf_flags), .irq(irq)
    );

    function automatic logic [7:0] exp_rdata(input logic [5:0] a);
        if (a == 6'h04) return m_cnt[15:8];
        if (a == 6'h05) return m_cnt[7:0];
        if (a == 6'h0A) return m_cie;
        if (a == 6'h0B) return {m_oie, 7'b0};
        if (a == 6'h0C) return m_ch;
        if (a == 6'h0D) return {m_ov, 7'b0};
        return 8'h00;
    endfunction

    function automatic logic exp_irq();
        return (|(m_ch & m_cie)) | (m_ov & m_oie);
    endfunction

    // channel clear vector from R5/R8
    function automatic logic [7:0] exp_ch_clr(input logic en, input logic fc,
            input logic [7:0] mode, input logic rq, input logic wr,
            input logic [5:0] a, input logic [7:0] wd);
        logic [7:0] c = '0;
        if (rq && wr && a == 6'h0C && en) c = wd;
        if (rq && fc && a[5:4] == 2'b01 && mode[a[3:1]] == wr) c[a[3:1]] = 1'b1;
        return c;
    endfunction

    // overflow clear from R5/R7
    function automatic logic exp_ov_clr(input logic en, input logic fc,
            input logic rq, input logic wr, input logic [5:0] a, input logic [7:0] wd);
        return (rq && wr && a == 6'h0D && en && wd[7]) ||
               (rq && fc && (a == 6'h04 || a == 6'h05));
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bus cycle, called at a falling edge
    task automatic step(input string req, input logic te, input logic pe,
            input logic fc, input logic [7:0] mode, input logic [7:0] evt,
            input logic rq, input logic wr, input logic [5:0] a, input logic [7:0] wd);
        logic       en;
        logic [7:0] nch;
        logic       nov;
        tmr_en = te; pacc_en = pe; fast_clr = fc; chan_mode = mode; ch_evt = evt;
        bus_req = rq; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        #1;
        if (rq && !wr) check({req, " R11 rdata"}, bus_rdata, exp_rdata(a));
        en  = te | pe;
        nch = (m_ch & ~exp_ch_clr(en, fc, mode, rq, wr, a, wd)) | evt;
        nov = (m_ov & ~exp_ov_clr(en, fc, rq, wr, a, wd)) | (en && m_cnt == 16'hFFFF);
        @(posedge clk);
        m_ch = nch;
        m_ov = nov;
        if (rq && wr && a == 6'h0A) m_cie = wd;
        if (rq && wr && a == 6'h0B) m_oie = wd[7];
        if (en) m_cnt = m_cnt + 16'd1;
        @(negedge clk);
        check({req, " ch_flags"}, ch_flags, m_ch);
        check({req, " ovf_flags"}, ovf_flags, {m_ov, 7'b0});
        check({req, " R10 irq"}, {7'b0, irq}, {7'b0, exp_irq()});
    endtask

    task automatic idle(input string req, input logic te, input logic pe);
        step(req, te, pe, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 6'h00, 8'h00);
    endtask

    task automatic rd(input string req, input logic [5:0] a);
        step(req, tmr_en, pacc_en, fast_clr, chan_mode, 8'h00, 1'b1, 1'b0, a, 8'h00);
    endtask

    initial begin
        #(20 * 190000);
        fails++;
        total++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ch_flags", ch_flags, 8'h00);
        check("R1 ovf_flags", ovf_flags, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        rd("R1", 6'h04); rd("R1", 6'h05); rd("R1", 6'h0A);
        rd("R1", 6'h0B); rd("R1", 6'h0C); rd("R1", 6'h0D);

        // R2 events set flags
        step("R2", 0, 0, 0, 8'h00, 8'hA5, 0, 0, 6'h00, 8'h00);
        rd("R2", 6'h0C);
        // R5 write-one clear and zero-write no effect
        step("R5", 1, 0, 0, 8'h00, 8'h00, 1, 1, 6'h0C, 8'h05);
        step("R5", 1, 0, 0, 8'h00, 8'h00, 1, 1, 6'h0C, 8'h00);
        // R6 locked with both enables low; R3 counter held
        step("R6", 0, 0, 0, 8'h00, 8'h00, 1, 1, 6'h0C, 8'hFF);
        step("R6", 0, 0, 1, 8'h00, 8'h00, 1, 1, 6'h0C, 8'hFF);
        rd("R3", 6'h05);
        idle("R3", 0, 0);
        rd("R3", 6'h05);
        // R5 clear via pulse-accumulator enable
        step("R5", 0, 1, 0, 8'h00, 8'h00, 1, 1, 6'h0C, 8'h20);
        // R9 event and clear collide
        step("R9", 1, 0, 0, 8'h00, 8'h80, 1, 1, 6'h0C, 8'h80);
        // R8 fast clear by channel role
        step("R8", 1, 0, 0, 8'h0F, 8'hFF, 0, 0, 6'h00, 8'h00);
        step("R8", 1, 0, 1, 8'h0F, 8'h00, 1, 0, 6'h10, 8'h00);
        step("R8", 1, 0, 1, 8'h0F, 8'h00, 1, 1, 6'h11, 8'h00);
        step("R8", 1, 0, 1, 8'h0F, 8'h00, 1, 0, 6'h1E, 8'h00);
        step("R8", 1, 0, 1, 8'h0F, 8'h00, 1, 1, 6'h1F, 8'h00);
        step("R8", 1, 0, 0, 8'h0F, 8'h00, 1, 0, 6'h1C, 8'h00);
        step("R8", 0, 0, 1, 8'h0F, 8'h00, 1, 1, 6'h17, 8'h00);
        rd("R8", 6'h0C);
        // R10 enables and irq
        step("R10", 0, 0, 0, 8'h00, 8'h00, 1, 1, 6'h0A, 8'h02);
        rd("R10", 6'h0A);
        step("R10", 0, 0, 0, 8'h00, 8'h00, 1, 1, 6'h0A, 8'h40);
        step("R10", 0, 0, 0, 8'h00, 8'h00, 1, 1, 6'h0B, 8'hFF);
        rd("R10", 6'h0B);

        // R4 first wrap, colliding with write-one clear (R9)
        while (m_cnt != 16'hFFFF) idle("R3 R4 run", 1, 0);
        step("R9 wrap", 1, 0, 0, 8'h00, 8'h00, 1, 1, 6'h0D, 8'h80);
        rd("R4", 6'h0D);
        step("R5", 1, 0, 0, 8'h00, 8'h00, 1, 1, 6'h0D, 8'h7F);
        step("R6", 0, 0, 0, 8'h00, 8'h00, 1, 1, 6'h0D, 8'h80);
        step("R5", 0, 1, 0, 8'h00, 8'h00, 1, 1, 6'h0D, 8'h80);
        // second wrap, fast clear counter read collides (R9), then clears (R7)
        while (m_cnt != 16'hFFFF) idle("R3 R4 run", 0, 1);
        step("R9 fc", 0, 1, 1, 8'h00, 8'h00, 1, 0, 6'h05, 8'h00);
        step("R7", 0, 0, 0, 8'h00, 8'h00, 1, 0, 6'h04, 8'h00);
        step("R7", 0, 0, 1, 8'h00, 8'h00, 1, 1, 6'h04, 8'h00);

        // random phase
        for (int k = 0; k < 3000; k++) begin
            logic [5:0] a;
            logic [3:0] pick = 4'($urandom % 10);
            unique case (pick)
                4'd0: a = 6'h04;
                4'd1: a = 6'h05;
                4'd2: a = 6'h0A;
                4'd3: a = 6'h0B;
                4'd4: a = 6'h0C;
                4'd5: a = 6'h0D;
                4'd6, 4'd7: a = 6'h10 | 6'($urandom % 16);
                4'd8: a = 6'h00;
                default: a = 6'($urandom);
            endcase
            step("R2 R5 R8 R9 random",
                 1'(($urandom % 4) == 0), 1'(($urandom % 4) == 0),
                 1'($urandom), 8'($urandom), 8'($urandom & $urandom & $urandom),
                 1'(($urandom % 4) != 0), 1'($urandom), a, 8'($urandom));
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule